// File: doc/BRIEF.md
# Clause 22 Management Bus Master

This block lets software run clause 22 management frames on a single MDC/MDIO bus through three 16-bit registers. Software writes the data word first when it wants a write. It then writes one control word that carries the PHY address, the register number and the two-bit operation code. That control write launches the frame. A status bit in the control register shows when the master is idle again. After a read frame, the 16 bits returned by the PHY can be read from the result register.

The block derives MDC from the system clock through a parameterised divider. MDC idles low between frames. The bidirectional MDIO line is presented as three plain signals: a driven value, an output enable and a sampled input. The pad outside the block combines them into the real line. The register port is a plain strobe interface: each write is taken in the cycle it is presented and never stalls. Reads are combinational from the address, so no back-pressure exists at this edge.

Top module: `mgmt_bus_master`

## Requirements
- R1: Registers are 16 bits wide at byte addresses 0 (control), 2 (write data) and 4 (read result); any other address reads as zero and writes there have no effect.
- R2: Control bits [4:0] carry the register number, [9:5] the PHY address and [11:10] the operation code (2'b01 write, 2'b10 read); reading the control register returns the fields of the last accepted command in the same positions, with bits [15:13] zero.
- R3: Control bit 12 reads 1 while the master is idle and 0 from the cycle after an accepted command until the frame ends.
- R4: A write frame is sent most significant bit first as 32 ones, start 01, opcode 01, PHY address, register number, turnaround 10 and the 16 data bits, with the output enable high for all 64 bits.
- R5: A read frame sends the same 46-bit header with opcode 10, then releases MDIO (output enable low) for the 2 turnaround and 16 data bits, samples MDIO on each rising MDC edge of the data bits, and shows the 16 sampled bits (first bit as bit 15) in the read result register once idle returns.
- R6: MDC high and low phases each last HALF_DIV system clocks (default 40, giving 2.5 MHz from a 200 MHz clock), so a frame of 64 MDC periods takes 128*HALF_DIV clocks (25.6 us by default).
- R7: MDIO output value and output enable change during a frame only on a falling MDC edge; while idle, MDC and the output enable are both low.
- R8: A control write while a frame is in progress is ignored: the running frame, the stored command fields and the bus are unaffected, and no second frame follows.
- R9: A control write with opcode 2'b00 or 2'b11 causes no MDC activity, leaves the block idle and leaves the stored command fields unchanged.
- R10: The read result register is zero after reset and keeps its value until the next read frame completes; write frames and ignored commands leave it unchanged.
- R11: The write data register may be rewritten at any time; a frame already running keeps sending the value captured at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, taken in the cycle it is high |
| reg_addr | input | 3 | Byte address of the register |
| reg_wdata | input | 16 | Register write value |
| reg_rdata | output | 16 | Register read value for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | High while the master drives MDIO |
| mdio_i | input | 1 | Value sampled from MDIO |

## Verification
The frame engine gets writes and reads with the address fields at all zeros, all ones and mixed values. The data words are alternating, all ones, all zeros and single-end bits. These cases expose field misplacement, bit-order reversal and an off-by-one in the sampling window. Reads are paired with a PHY model that answers on falling MDC. A header mismatch, a wrong release point of the output enable or a shifted result word therefore shows separately. Directed cases cover a command issued during a running frame, the two inert opcodes, rewriting the data register mid-frame, and the result register surviving write frames.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int REG_W       = 16;
  localparam int FIELD_W     = 5;
  localparam int FRAME_BITS  = 64;
  localparam int PRE_BITS    = 32;
  localparam int HDR_BITS    = PRE_BITS + 2 + 2 + 2 * FIELD_W;  // driven in reads
  localparam int DATA_BITS   = 16;
  localparam int DATA_START  = FRAME_BITS - DATA_BITS;
  localparam int IDX_W       = $clog2(FRAME_BITS);
  localparam int IDLE_BIT    = 12;

  typedef enum logic [1:0] {
    OP_NOP0  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_NOP3  = 2'b11
  } mgmt_op_e;

  typedef struct packed {
    mgmt_op_e             op;
    logic [FIELD_W-1:0]   phy;
    logic [FIELD_W-1:0]   regn;
  } mgmt_cmd_t;
endpackage

// File: rtl/mgmt_mdc_gen.sv
module mgmt_mdc_gen #(
  parameter int HALF_DIV = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_p,
  output logic fall_p
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = run && (cnt_q == LAST);
  assign rise_p = wrap && !mdc;
  assign fall_p = wrap && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc   <= ~mdc;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mgmt_frame_eng.sv
module mgmt_frame_eng
  import mgmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  mgmt_cmd_t            cmd,
  input  logic [REG_W-1:0]     wdata,
  input  logic                 rise_p,
  input  logic                 fall_p,
  input  logic                 mdio_i,
  output logic                 busy,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 rd_load,
  output logic [DATA_BITS-1:0] rd_value
);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] HDR_IDX   = IDX_W'(HDR_BITS);
  localparam logic [IDX_W-1:0] DATA_IDX  = IDX_W'(DATA_START);

  logic [FRAME_BITS-1:0] frame_q;
  logic [FRAME_BITS-1:0] frame_d;
  logic [IDX_W-1:0]      idx_q;
  logic                  is_rd_q;
  logic [DATA_BITS-1:0]  rx_q;
  logic [1:0]            ta_bits;

  assign ta_bits = (cmd.op == OP_READ) ? 2'b11 : 2'b10;
  assign frame_d = {{PRE_BITS{1'b1}}, 2'b01, cmd.op, cmd.phy, cmd.regn,
                    ta_bits, wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      frame_q <= '0;
      idx_q   <= '0;
      is_rd_q <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        frame_q <= frame_d;
        idx_q   <= '0;
        is_rd_q <= (cmd.op == OP_READ);
      end
    end else if (fall_p) begin
      if (idx_q == LAST_IDX) begin
        busy    <= 1'b0;
        frame_q <= '0;
      end else begin
        idx_q   <= idx_q + 1'b1;
        frame_q <= {frame_q[FRAME_BITS-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0;
    end else if (busy && rise_p && is_rd_q && (idx_q >= DATA_IDX)) begin
      rx_q <= {rx_q[DATA_BITS-2:0], mdio_i};
    end
  end

  assign mdio_o   = busy && frame_q[FRAME_BITS-1];
  assign mdio_oe  = busy && (!is_rd_q || (idx_q < HDR_IDX));
  assign rd_load  = busy && fall_p && is_rd_q && (idx_q == LAST_IDX);
  assign rd_value = rx_q;
endmodule

// File: rtl/mgmt_reg_bank.sv
module mgmt_reg_bank
  import mgmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [2:0]           addr,
  input  logic [REG_W-1:0]     wdata,
  input  logic                 busy,
  input  logic                 rd_load,
  input  logic [DATA_BITS-1:0] rd_value,
  output logic [REG_W-1:0]     rdata,
  output logic                 start,
  output mgmt_cmd_t            cmd_q,
  output mgmt_cmd_t            cmd_new,
  output logic [REG_W-1:0]     wr_data_q,
  output logic [DATA_BITS-1:0] rd_hold_q
);
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_WDAT = 3'd2;
  localparam logic [2:0] A_RDAT = 3'd4;
  localparam int CMD_W = $bits(mgmt_cmd_t);

  logic ctrl_we;
  logic op_active;

  assign cmd_new   = mgmt_cmd_t'(wdata[CMD_W-1:0]);
  assign ctrl_we   = we && (addr == A_CTRL);
  assign op_active = (cmd_new.op == OP_WRITE) || (cmd_new.op == OP_READ);
  assign start     = ctrl_we && !busy && op_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      wr_data_q <= '0;
      rd_hold_q <= '0;
    end else begin
      if (start)                    cmd_q     <= cmd_new;
      if (we && (addr == A_WDAT))   wr_data_q <= wdata;
      if (rd_load)                  rd_hold_q <= rd_value;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[CMD_W-1:0] = cmd_q;
        rdata[IDLE_BIT]  = !busy;
      end
      A_WDAT:  rdata = wr_data_q;
      A_RDAT:  rdata = rd_hold_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/mgmt_bus_master.sv
module mgmt_bus_master
  import mgmt_pkg::*;
#(
  parameter int HALF_DIV = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic                 busy;
  logic                 start;
  logic                 rise_p;
  logic                 fall_p;
  logic                 rd_load;
  logic [DATA_BITS-1:0] rd_value;
  logic [DATA_BITS-1:0] rd_q;
  logic [REG_W-1:0]     wr_data;
  mgmt_cmd_t            cmd_q;
  mgmt_cmd_t            cmd_new;

  mgmt_reg_bank u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .busy      (busy),
    .rd_load   (rd_load),
    .rd_value  (rd_value),
    .rdata     (reg_rdata),
    .start     (start),
    .cmd_q     (cmd_q),
    .cmd_new   (cmd_new),
    .wr_data_q (wr_data),
    .rd_hold_q (rd_q)
  );

  mgmt_mdc_gen #(.HALF_DIV(HALF_DIV)) u_mdc (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (busy),
    .mdc    (mdc),
    .rise_p (rise_p),
    .fall_p (fall_p)
  );

  mgmt_frame_eng u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cmd      (cmd_new),
    .wdata    (wr_data),
    .rise_p   (rise_p),
    .fall_p   (fall_p),
    .mdio_i   (mdio_i),
    .busy     (busy),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rd_load  (rd_load),
    .rd_value (rd_value)
  );
endmodule

// File: rtl/mgmt_bus_master_chk.sv
module mgmt_bus_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [11:0] cmd_bits,
  input logic        rd_load,
  input logic [15:0] rd_q
);
  // R7: bus quiet between frames
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  // R7: driven value moves only with a falling MDC
  p_data_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));

  // R7: output enable moves only with a falling MDC
  p_oe_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_oe)) |-> $fell(mdc));

  // R8: stored command frozen for the whole frame
  p_cmd_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_bits));

  // R10: result register changes only on a completed read
  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_load |=> $stable(rd_q));
endmodule

bind mgmt_bus_master mgmt_bus_master_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .mdc      (mdc),
  .mdio_o   (mdio_o),
  .mdio_oe  (mdio_oe),
  .cmd_bits (cmd_q),
  .rd_load  (rd_load),
  .rd_q     (rd_q)
);

// File: tb/mgmt_bus_master_tb_top.sv
`timescale 1ns/1ps
module mgmt_bus_master_tb_top;
  localparam int HALF_DIV = 40;
  localparam int NV = 6;
  // {op[1:0], phy[4:0], reg[4:0], data[15:0]}
  localparam logic [27:0] VECS [NV] = '{
    {2'b01, 5'd1,  5'd0,  16'hA5C3},
    {2'b10, 5'd1,  5'd2,  16'h1234},
    {2'b01, 5'd31, 5'd31, 16'hFFFF},
    {2'b10, 5'd0,  5'd0,  16'h0000},
    {2'b10, 5'd31, 5'd31, 16'h8001},
    {2'b01, 5'd0,  5'd17, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        phy_drv = 1'b0;

  int total = 0;
  int bad = 0;

  logic [63:0] cap;
  logic [63:0] oe_cap;
  int          rises;
  logic [15:0] resp;
  realtime     t_prev, t_last;

  always #2.5 clk = ~clk;

  mgmt_bus_master #(.HALF_DIV(HALF_DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(phy_drv)
  );

  // PHY model: records the line at each rising MDC, answers on falling MDC
  always @(posedge mdc) begin
    cap    = {cap[62:0], mdio_oe ? mdio_o : 1'b0};
    oe_cap = {oe_cap[62:0], mdio_oe};
    rises  = rises + 1;
    t_prev = t_last;
    t_last = $realtime;
  end

  always @(negedge mdc) begin
    if (rises >= 48 && rises <= 63) phy_drv = resp[63 - rises];
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic clear_phy();
    cap = '0; oe_cap = '0; rises = 0;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int i = 0; i < 20000; i++) begin
      reg_read(3'd0, v);
      if (v[12]) break;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [63:0] exp;
    logic [11:0] cmd;
    clear_phy();
    resp = '0;
    t_prev = 0; t_last = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    reg_read(3'd0, v); check(v == 16'h1000, "R3 reset control", v, 16'h1000);
    reg_read(3'd4, v); check(v == 16'h0000, "R10 reset result", v, 0);
    reg_read(3'd2, v); check(v == 16'h0000, "R1 reset wdata", v, 0);
    check(!mdc && !mdio_oe, "R7 idle bus", {mdc, mdio_oe}, 0);
    reg_write(3'd6, 16'hBEEF);
    reg_read(3'd6, v); check(v == 16'h0000, "R1 unmapped address", v, 0);

    // table walk
    for (int k = 0; k < NV; k++) begin
      logic [1:0]  op;
      logic [15:0] dat;
      op  = VECS[k][27:26];
      dat = VECS[k][15:0];
      cmd = VECS[k][27:16];
      clear_phy();
      resp = dat;
      if (op == 2'b01) reg_write(3'd2, dat);
      reg_write(3'd0, {4'b0, cmd});
      reg_read(3'd0, v);
      check(v[12] == 1'b0, "R3 busy flag", v, 0);
      wait_idle();
      exp = {32'hFFFF_FFFF, 2'b01, cmd, 2'b10, dat};
      check(rises == 64, "R6 MDC periods per frame", rises, 64);
      if (op == 2'b01) begin
        check(cap == exp, "R4 write frame", cap, exp);
        check(oe_cap == '1, "R4 write drive", oe_cap, '1);
      end else begin
        check(cap[63:18] == exp[63:18], "R5 read header", cap[63:18], exp[63:18]);
        check(oe_cap == {{46{1'b1}}, 18'b0}, "R5 read release", oe_cap,
              {{46{1'b1}}, 18'b0});
        reg_read(3'd4, v); check(v == dat, "R5 read result", v, dat);
      end
      reg_read(3'd0, v);
      check(v == {4'b0001, cmd}, "R2 control readback", v, {4'b0001, cmd});
      if (k == 0) begin
        check((t_last - t_prev) == 2.0 * HALF_DIV * 5.0, "R6 MDC period",
              64'(int'(t_last - t_prev)), 64'(2 * HALF_DIV * 5));
      end
    end

    // R10: the final write frame kept the earlier read result
    reg_read(3'd4, v); check(v == 16'h8001, "R10 result held", v, 16'h8001);

    // R8: command during a frame is ignored
    clear_phy();
    reg_write(3'd2, 16'h0F0F);
    reg_write(3'd0, {4'b0, 2'b01, 5'd3, 5'd4});
    repeat (200) @(negedge clk);
    reg_write(3'd0, {4'b0, 2'b10, 5'd9, 5'd9});
    wait_idle();
    repeat (2000) @(negedge clk);
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd3, 5'd4, 2'b10, 16'h0F0F};
    check(rises == 64, "R8 no second frame", rises, 64);
    check(cap == exp, "R8 frame undisturbed", cap, exp);
    reg_read(3'd0, v);
    check(v == {4'b0001, 2'b01, 5'd3, 5'd4}, "R8 fields kept", v,
          {4'b0001, 2'b01, 5'd3, 5'd4});
    reg_read(3'd4, v); check(v == 16'h8001, "R10 result after ignored read", v, 16'h8001);

    // R9: inert opcodes
    for (int q = 0; q < 2; q++) begin
      logic [1:0] nop;
      nop = (q == 0) ? 2'b00 : 2'b11;
      clear_phy();
      reg_write(3'd0, {4'b0, nop, 5'd7, 5'd7});
      reg_read(3'd0, v);
      check(v == {4'b0001, 2'b01, 5'd3, 5'd4}, "R9 idle and fields kept", v,
            {4'b0001, 2'b01, 5'd3, 5'd4});
      repeat (500) @(negedge clk);
      check(rises == 0, "R9 no MDC activity", rises, 0);
    end

    // R11: data register rewritten mid-frame
    clear_phy();
    reg_write(3'd2, 16'h3C5A);
    reg_write(3'd0, {4'b0, 2'b01, 5'd5, 5'd6});
    repeat (100) @(negedge clk);
    reg_write(3'd2, 16'hC3A5);
    wait_idle();
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd5, 5'd6, 2'b10, 16'h3C5A};
    check(cap == exp, "R11 frame keeps start data", cap, exp);
    reg_read(3'd2, v); check(v == 16'hC3A5, "R11 data register updated", v, 16'hC3A5);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule